// File: doc/BRIEF.md
# Event spy buffer controller

The block sits beside an event data path and copies events into a local circular SRAM so that a separate host-side reader can drain them. Events arrive as 64-bit words marked with start-of-event and end-of-event flags. Each word of an accepted event is written to the SRAM through a simple synchronous write port in the cycle it is accepted. The host drains the buffer on its own schedule and then reports its new read pointer, which frees the space it has consumed.

There are two capture modes. In counted mode the block records a programmed number of whole events (1 to 1024) and then writes one status word. If the buffer runs short first, it writes the status word early and sets a truncation flag. Counted mode never stalls the data path. In capture-all mode every event is recorded. When the buffer cannot hold another maximum-size event, the block deasserts its ready output between events, so the upstream source waits and no event is lost. Events are at most `MAX_EV` words long.

A restart pulse clears the pointers, the counters and the flags. Mode and count settings are sampled only at the start of an event.

Top module: `evspy_top`

## Requirements
- R1: After reset or a one-cycle `cfg_restart` pulse, `stat_wp` is 0, `stat_events` is 0, `stat_trunc` and `stat_done` are 0, `stat_free` equals the depth (256 by default) and `in_ready` is 1.
- R2: Each word of an accepted event is driven on `mem_wdata` unchanged, with `mem_we` high, in the same cycle it is accepted (`in_valid` and `in_ready`). Its address is the write pointer modulo the depth, and successive words take consecutive addresses that wrap at the depth.
- R3: In counted mode, once the event that brings the event count to the target has ended, the next cycle writes one status word at the next address. The status word is laid out as bits 63:48 = 16'hE5C0, bit 32 = truncation flag, bits 15:0 = events captured, and all other bits zero. After that, `stat_done` is 1 and nothing more is written until restart. A programmed count of 0 acts as 1, and counts above 1024 act as 1024.
- R4: In counted mode an event is captured only if, at its first word, `stat_free` is at least `MAX_EV`+1. Otherwise no data word of that event is written. Instead, in that start cycle the status word is written with the truncation flag set, and `stat_trunc` and `stat_done` become 1.
- R5: In counted mode `in_ready` is always 1.
- R6: In capture-all mode every event is written in full, `stat_events` counts each completed event, and no status word is written.
- R7: In capture-all mode, between events, `in_ready` is 0 while `stat_free` is below `MAX_EV`. It returns to 1 in the cycle after the host pointer update that makes `stat_free` at least `MAX_EV`.
- R8: `stat_free` equals the depth minus (`stat_wp` minus the last host read pointer), where the pointers are AW+1 bits wide including a wrap bit.
- R9: Changes to `cfg_all` or `cfg_count` while an event is in progress do not affect that event. Its mode and target are the values seen at its first word.
- R10: Words presented with `in_valid` outside an event and without a start flag are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_all | input | 1 | 1 = capture-all mode, 0 = counted mode |
| cfg_count | input | 11 | Target event count for counted mode |
| cfg_restart | input | 1 | One-cycle pulse that clears pointers, counters and flags |
| in_valid | input | 1 | Event word present |
| in_sop | input | 1 | First word of an event |
| in_eop | input | 1 | Last word of an event |
| in_data | input | 64 | Event word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW (8) | SRAM write address |
| mem_wdata | output | 64 | SRAM write data |
| host_rp_we | input | 1 | Host read-pointer update strobe |
| host_rp | input | AW+1 (9) | New host read pointer, including the wrap bit |
| stat_wp | output | AW+1 (9) | Write pointer, including the wrap bit |
| stat_free | output | AW+1 (9) | Free words in the buffer |
| stat_events | output | 16 | Events captured since restart |
| stat_trunc | output | 1 | Counted capture was cut short by lack of space |
| stat_done | output | 1 | Counted capture has finished |

## Verification
A wrong write pointer shows up on the very first SRAM write as a wrong `mem_addr`, or later as a `stat_free` value that disagrees with the host pointer. A wrong free-space count shows up at the next event boundary: in capture-all mode as a stall that should not happen or a missing stall, and in counted mode as a truncation that is early or late. A wrong event count or a stale target shows up at the end of a counted capture, as a status word that is missing, early or extra, or that carries the wrong count. An unexpected write after `stat_done` appears on the SRAM port in the very cycle it happens.

// File: rtl/evspy_pkg.sv
package evspy_pkg;

    localparam int DW         = 64;
    localparam int CFG_W      = 11;
    localparam int MAX_TARGET = 1024;
    localparam logic [15:0] STAT_TAG = 16'hE5C0;

    typedef enum logic [1:0] {
        S_GAP  = 2'd0,
        S_EVT  = 2'd1,
        S_STAT = 2'd2,
        S_DONE = 2'd3
    } cap_state_e;

    // Status record: tag in [63:48], truncation flag in bit 32, count in [15:0]
    function automatic logic [DW-1:0] make_status(input logic trunc, input logic [15:0] n);
        return {STAT_TAG, 15'd0, trunc, 16'd0, n};
    endfunction

    function automatic logic [CFG_W-1:0] clamp_target(input logic [CFG_W-1:0] c);
        if (c == '0)
            return CFG_W'(1);
        if (c > CFG_W'(MAX_TARGET))
            return CFG_W'(MAX_TARGET);
        return c;
    endfunction

endpackage

// File: rtl/evspy_ptrs.sv
module evspy_ptrs #(
    parameter int AW     = 8,
    parameter int MAX_EV = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        wr_inc,
    input  logic        rp_we,
    input  logic [AW:0] rp_in,
    output logic [AW:0] wp,
    output logic [AW:0] free
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

    logic [AW:0] rp;
    logic [AW:0] used;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_inc)
                wp <= wp + (AW+1)'(1);
            if (rp_we)
                rp <= rp_in;
        end
    end

    always_comb begin
        used = wp - rp;
        free = DEPTH_V - used;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_inc |-> free != '0); // R4

    AST_USED_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wp - rp) <= DEPTH_V); // R8

endmodule

// File: rtl/evspy_ctrl.sv
module evspy_ctrl
    import evspy_pkg::*;
#(
    parameter int AW     = 8,
    parameter int MAX_EV = 16,
    parameter int CW     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             cfg_all,
    input  logic [CFG_W-1:0] cfg_count,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [DW-1:0]    in_data,
    input  logic [AW:0]      free,
    output logic             in_ready,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic [CW-1:0]    events,
    output logic             trunc,
    output logic             done
);
    cap_state_e       state, st_n;
    logic             act_all, all_n;
    logic [CFG_W-1:0] act_tgt, tgt_n, tgt_new;
    logic [CW-1:0]    ev_n, ev_inc;
    logic             tr_n;
    logic             room_all, room_cnt, acc;

    always_comb begin
        room_all = free >= (AW+1)'(MAX_EV);
        room_cnt = free >= (AW+1)'(MAX_EV + 1);
        tgt_new  = clamp_target(cfg_count);
        in_ready = (state == S_GAP && cfg_all) ? room_all : 1'b1;
        acc      = in_valid && in_ready;
        ev_inc   = events + CW'(1);
    end

    always_comb begin
        st_n    = state;
        all_n   = act_all;
        tgt_n   = act_tgt;
        ev_n    = events;
        tr_n    = trunc;
        wr_en   = 1'b0;
        wr_data = in_data;
        unique case (state)
            S_GAP: begin
                if (acc && in_sop) begin
                    if (cfg_all || room_cnt) begin
                        wr_en = 1'b1;
                        all_n = cfg_all;
                        tgt_n = tgt_new;
                        if (in_eop) begin
                            ev_n = ev_inc;
                            if (!cfg_all && ev_inc == CW'(tgt_new))
                                st_n = S_STAT;
                        end else begin
                            st_n = S_EVT;
                        end
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = make_status(1'b1, 16'(events));
                        tr_n    = 1'b1;
                        st_n    = S_DONE;
                    end
                end
            end
            S_EVT: begin
                if (acc) begin
                    wr_en = 1'b1;
                    if (in_eop) begin
                        ev_n = ev_inc;
                        st_n = (!act_all && ev_inc == CW'(act_tgt)) ? S_STAT : S_GAP;
                    end
                end
            end
            S_STAT: begin
                wr_en   = 1'b1;
                wr_data = make_status(trunc, 16'(events));
                st_n    = S_DONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state   <= S_GAP;
            act_all <= 1'b0;
            act_tgt <= CFG_W'(1);
            events  <= '0;
            trunc   <= 1'b0;
        end else begin
            state   <= st_n;
            act_all <= all_n;
            act_tgt <= tgt_n;
            events  <= ev_n;
            trunc   <= tr_n;
        end
    end

    assign done = (state == S_DONE);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == S_DONE && !restart) |=> state == S_DONE); // R3

    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en); // R3

    AST_TRUNC_ENDS: assert property (@(posedge clk) disable iff (rst)
        $rose(trunc) |-> done); // R4

    AST_GAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == S_GAP && !in_sop) |-> !wr_en); // R10

endmodule

// File: rtl/evspy_top.sv
module evspy_top
    import evspy_pkg::*;
#(
    parameter int AW     = 8,
    parameter int MAX_EV = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_all,
    input  logic [10:0]      cfg_count,
    input  logic             cfg_restart,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [63:0]      in_data,
    output logic             in_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic             host_rp_we,
    input  logic [AW:0]      host_rp,
    output logic [AW:0]      stat_wp,
    output logic [AW:0]      stat_free,
    output logic [15:0]      stat_events,
    output logic             stat_trunc,
    output logic             stat_done
);
    logic [AW:0] wp, free;

    evspy_ptrs #(.AW(AW), .MAX_EV(MAX_EV)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_restart),
        .wr_inc  (mem_we),
        .rp_we   (host_rp_we),
        .rp_in   (host_rp),
        .wp      (wp),
        .free    (free)
    );

    evspy_ctrl #(.AW(AW), .MAX_EV(MAX_EV), .CW(16)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .restart   (cfg_restart),
        .cfg_all   (cfg_all),
        .cfg_count (cfg_count),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .free      (free),
        .in_ready  (in_ready),
        .wr_en     (mem_we),
        .wr_data   (mem_wdata),
        .events    (stat_events),
        .trunc     (stat_trunc),
        .done      (stat_done)
    );

    assign mem_addr  = wp[AW-1:0];
    assign stat_wp   = wp;
    assign stat_free = free;

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_restart |=> (stat_wp == '0 && stat_events == '0 && !stat_done && !stat_trunc)); // R1

    AST_STATUS_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(mem_we)); // R3

    AST_BP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> stat_free < (AW+1)'(MAX_EV)); // R7

endmodule

// File: tb/tb_evspy_top.sv
module tb_evspy_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_all = 1'b0;
    logic [10:0] cfg_count = 11'd1;
    logic        cfg_restart = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_ready;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [63:0] mem_wdata;
    logic        host_rp_we = 1'b0;
    logic [8:0]  host_rp = '0;
    logic [8:0]  stat_wp, stat_free;
    logic [15:0] stat_events;
    logic        stat_trunc, stat_done;

    int errors = 0;
    int checks = 0;
    int exp_addr = 0;
    logic [7:0]  q_addr[$];
    logic [63:0] q_data[$];

    evspy_top dut (
        .clk(clk), .rst(rst), .cfg_all(cfg_all), .cfg_count(cfg_count),
        .cfg_restart(cfg_restart), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .host_rp_we(host_rp_we), .host_rp(host_rp), .stat_wp(stat_wp),
        .stat_free(stat_free), .stat_events(stat_events),
        .stat_trunc(stat_trunc), .stat_done(stat_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: every SRAM write must match the head of the expected queue
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R2/R3/R10 unexpected write", {56'd0, mem_addr}, 64'd0);
            end else begin
                logic [7:0]  ea;
                logic [63:0] ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                chk(mem_addr == ea, "R2 address", {56'd0, mem_addr}, {56'd0, ea});
                chk(mem_wdata == ed, "R2/R3 data", mem_wdata, ed);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_exp(input logic [63:0] d);
        q_addr.push_back(8'(exp_addr % DEPTH));
        q_data.push_back(d);
        exp_addr++;
    endtask

    task automatic put_word(input bit s, input bit e, input logic [63:0] d, input bit expect_wr);
        in_valid = 1'b1; in_sop = s; in_eop = e; in_data = d;
        if (expect_wr) push_exp(d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        tick();
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_event(input int len, input int tag, input bit expect_wr);
        for (int i = 0; i < len; i++)
            put_word(i == 0, i == len - 1, {tag[31:0], i[31:0]}, expect_wr);
    endtask

    task automatic expect_status(input bit tr, input int n);
        push_exp({16'hE5C0, 15'd0, tr, 16'd0, n[15:0]});
    endtask

    task automatic restart();
        cfg_restart = 1'b1;
        tick();
        cfg_restart = 1'b0;
        exp_addr = 0;
    endtask

    task automatic set_rp(input int v);
        host_rp_we = 1'b1; host_rp = 9'(v);
        tick();
        host_rp_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk(stat_wp == 0, "R1 wp", 64'(stat_wp), 0);
        chk(stat_free == 9'd256, "R1 free", 64'(stat_free), 256);
        chk(stat_events == 0 && !stat_done && !stat_trunc, "R1 counters",
            {stat_events, stat_done, stat_trunc}, 0);
        chk(in_ready && !mem_we, "R1 ready/idle", {in_ready, mem_we}, 2'b10);

        // R10: stray word outside an event is dropped
        put_word(1'b0, 1'b0, 64'hDEAD, 1'b0);
        chk(stat_wp == 0, "R10 no write", 64'(stat_wp), 0);

        // R3/R5: counted capture of three events
        cfg_all = 1'b0; cfg_count = 11'd3;
        send_event(4, 1, 1'b1);
        chk(in_ready, "R5 ready in counted mode", 64'(in_ready), 1);
        send_event(1, 2, 1'b1);
        send_event(5, 3, 1'b1);
        expect_status(1'b0, 3);
        tick();
        chk(stat_done && !stat_trunc, "R3 done", {stat_done, stat_trunc}, 2'b10);
        chk(stat_events == 3, "R3 events", 64'(stat_events), 3);
        chk(stat_wp == 11, "R3 wp after status", 64'(stat_wp), 11);
        send_event(2, 9, 1'b0);
        chk(stat_wp == 11, "R3 no writes after done", 64'(stat_wp), 11);

        // R1: restart clears
        restart();
        chk(stat_wp == 0 && stat_events == 0 && !stat_done, "R1 restart",
            {stat_wp, stat_events, stat_done}, 0);

        // R9: mid-event configuration change
        cfg_count = 11'd1;
        put_word(1'b1, 1'b0, 64'h11, 1'b1);
        cfg_count = 11'd5; cfg_all = 1'b1;
        put_word(1'b0, 1'b0, 64'h12, 1'b1);
        put_word(1'b0, 1'b1, 64'h13, 1'b1);
        expect_status(1'b0, 1);
        tick();
        chk(stat_done, "R9 latched target", 64'(stat_done), 1);
        cfg_all = 1'b0;

        // R4: truncation in counted mode
        restart();
        cfg_count = 11'd100;
        for (int k = 0; k < 15; k++) send_event(16, 100 + k, 1'b1);
        chk(stat_free == 16, "R4 free before skip", 64'(stat_free), 16);
        expect_status(1'b1, 15);
        send_event(16, 200, 1'b0);
        chk(stat_trunc && stat_done, "R4 trunc+done", {stat_trunc, stat_done}, 2'b11);
        chk(stat_events == 15, "R4 events", 64'(stat_events), 15);
        chk(stat_wp == 241, "R4 wp", 64'(stat_wp), 241);

        // R6/R7/R8: capture-all with backpressure
        restart();
        cfg_all = 1'b1;
        for (int k = 0; k < 16; k++) send_event(16, 300 + k, 1'b1);
        chk(stat_free == 0, "R8 free full", 64'(stat_free), 0);
        chk(!in_ready, "R7 backpressure", 64'(in_ready), 0);
        chk(stat_events == 16, "R6 events", 64'(stat_events), 16);
        set_rp(15);
        chk(stat_free == 15, "R8 free after rp", 64'(stat_free), 15);
        chk(!in_ready, "R7 still held with 15 free", 64'(in_ready), 0);
        set_rp(16);
        chk(in_ready, "R7 released", 64'(in_ready), 1);
        send_event(16, 400, 1'b1);
        chk(!in_ready, "R7 held again", 64'(in_ready), 0);
        fork
            send_event(16, 500, 1'b1);
            begin
                repeat (3) tick();
                chk(stat_wp == 272, "R7 stalled no write", 64'(stat_wp), 272);
                set_rp(32);
            end
        join
        chk(stat_events == 18 && !stat_done, "R6 all events, no status",
            {stat_events, stat_done}, {16'd18, 1'b0});
        chk(stat_wp == 288, "R2 wrapped pointer", 64'(stat_wp), 288);

        tick();
        chk(q_addr.size() == 0, "R2 all expected writes seen", 64'(q_addr.size()), 0);
        summary();
        $finish;
    end

endmodule